// File: doc/BRIEF.md
# Machine-Cycle Rate Divider with Automatic Fast-Rate Return

This block produces the one-clock-wide cycle enable that paces every clocked function of a small microcontroller-style core. Two rates are available: a standard rate with one enable pulse every 4 input clocks, and a power-managed rate with one pulse every 1024 input clocks. Software picks the rate by writing a two-bit divisor code through a simple configuration write port. The same write also sets a switchback enable bit.

When switchback is enabled and the slow rate is active, the block returns to the standard rate by itself on any of three hardware events. The first is an acknowledged interrupt. The second is a start bit detected by a serial receiver, which arrives before the character completes. The third is a load of a serial transmit buffer. Because a rate change in the middle of a serial transfer would corrupt it, divisor writes are dropped while any serial port reports activity. The block also captures a status word that holds the in-service interrupt levels and the per-port serial activity flags, so software can decide whether entering the slow rate is safe.

The interrupt controller only raises its acknowledge for an enabled interrupt that wins priority arbitration. This means a masked request, or one blocked by a level already in service, never reaches this block.

Top module: `clk_rate_switchback`

## Requirements
- R1: A synchronous active-high reset sets the divisor code to 2'b00, clears switchback enable and clears the status word. The first cycle enable appears on the 3rd clock edge after reset is released.
- R2: With divisor code 2'b00, 2'b01 or 2'b10, the cycle enable is high for one clock in every 4.
- R3: With divisor code 2'b11, the cycle enable is high for one clock in every 1024.
- R4: An accepted write that changes the rate, from slow to standard or the reverse, restarts the divisor count. The first enable then comes 3 edges after the write edge for the standard rate, or 1023 edges after it for the slow rate. A write that keeps the same rate leaves the tick phase untouched.
- R5: With switchback enabled and code 2'b11 active, an interrupt acknowledge sets the code to 2'b00 at that same edge and restarts the count.
- R6: Under the same conditions, a start-bit strobe from any serial port causes the same return.
- R7: Under the same conditions, a transmit-buffer load strobe from any serial port causes the same return.
- R8: With switchback disabled, the three event strobes leave code 2'b11 in place.
- R9: The event strobes have no effect while the standard rate is active. In particular, they do not restart the count.
- R10: While any serial busy flag is set, the divisor field of a write is ignored, but the switchback enable field of that write still takes effect.
- R11: The status word is the registered value of {power-fail in service, high in service, low in service, busy[NUM_SER-1:0]}. The MSB holds power-fail and bit i holds port i busy. It follows its inputs one clock later.
- R12: When a switchback event and a write of code 2'b11 land on the same edge, the switchback wins and the code becomes 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDiv | input | 2 | Divisor code to write (2'b11 slow, else standard) |
| cfgSwbEn | input | 1 | Switchback enable value to write |
| irqAck | input | 1 | Interrupt acknowledged this clock |
| rxStart | input | NUM_SER | Per-port receive start-bit strobe |
| txLoad | input | NUM_SER | Per-port transmit buffer load strobe |
| serBusy | input | NUM_SER | Per-port transfer-in-progress flag |
| inSvc | input | 3 | In-service levels {power-fail, high, low} |
| cycleEn | output | 1 | Machine-cycle enable pulse |
| divCode | output | 2 | Current divisor code |
| swbEn | output | 1 | Current switchback enable |
| status | output | NUM_SER+3 | Registered level and busy flags |

## Verification
The bench targets the count restart. A design that keeps counting across a rate change would give a first slow tick after a fast leftover count, or a short fast tick after leaving the slow rate. A design that restarts on a same-rate write or on a fast-mode event would shift the tick phase by a few clocks. The bench also drives writes during serial activity. A design that drops the whole write would lose the switchback enable update, and one that accepts the divisor field would enter the slow rate mid-transfer. Finally, the bench collides a write with a switchback event and drives events with switchback disabled. A wrong priority or a missing enable gate would leave the core stuck slow, or kick it fast without cause.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam logic [1:0] DIV_STD  = 2'b00;
  localparam logic [1:0] DIV_SLOW = 2'b11;

  typedef struct packed {
    logic       loadDiv;
    logic [1:0] divVal;
    logic       restart;
  } rateStrobe_t;

  function automatic logic isSlow(input logic [1:0] code);
    return code == DIV_SLOW;
  endfunction

endpackage

// File: rtl/crs_control.sv
module crs_control
  import crs_pkg::*;
#(
  parameter int NUM_SER = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgDiv,
  input  logic               cfgSwbEn,
  input  logic               irqAck,
  input  logic [NUM_SER-1:0] rxStart,
  input  logic [NUM_SER-1:0] txLoad,
  input  logic [NUM_SER-1:0] serBusy,
  input  logic [1:0]         curDiv,
  output rateStrobe_t        strb,
  output logic               swbEnQ
);

  logic anyEvt;
  logic swbFire;
  logic wrAccept;
  logic [1:0] nextDiv;

  always_ff @(posedge clk) begin
    if (rst)          swbEnQ <= 1'b0;
    else if (cfgWrEn) swbEnQ <= cfgSwbEn;
  end

  always_comb begin
    anyEvt   = irqAck | (|rxStart) | (|txLoad);
    swbFire  = swbEnQ && isSlow(curDiv) && anyEvt;
    wrAccept = cfgWrEn && !(|serBusy);
    if (swbFire)       nextDiv = DIV_STD;
    else if (wrAccept) nextDiv = cfgDiv;
    else               nextDiv = curDiv;
    strb.loadDiv = swbFire | wrAccept;
    strb.divVal  = nextDiv;
    strb.restart = isSlow(nextDiv) != isSlow(curDiv);
  end

  // R5: acknowledged interrupt leaves the slow rate
  a_r5_ack_returns: assert property (@(posedge clk) disable iff (rst)
    (swbEnQ && isSlow(curDiv) && irqAck) |=> (curDiv == DIV_STD));

  // R6: start bit leaves the slow rate
  a_r6_rx_returns: assert property (@(posedge clk) disable iff (rst)
    (swbEnQ && isSlow(curDiv) && |rxStart) |=> (curDiv == DIV_STD));

  // R7: transmit load leaves the slow rate
  a_r7_tx_returns: assert property (@(posedge clk) disable iff (rst)
    (swbEnQ && isSlow(curDiv) && |txLoad) |=> (curDiv == DIV_STD));

  // R8: no automatic return when disabled
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!swbEnQ && isSlow(curDiv) && !cfgWrEn) |=> isSlow(curDiv));

  // R10: divisor frozen by serial activity
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && (|serBusy) && !swbFire) |=> $stable(curDiv));

  // R10: enable field still written during activity
  a_r10_swb_written: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (swbEnQ == $past(cfgSwbEn)));

endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int NUM_SER  = 2,
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  rateStrobe_t        strb,
  input  logic [2:0]         inSvc,
  input  logic [NUM_SER-1:0] serBusy,
  output logic [1:0]         curDiv,
  output logic               cycleEn,
  output logic [NUM_SER+2:0] statusQ
);

  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);

  logic [1:0]       divQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limNow;

  always_comb limNow = isSlow(divQ) ? SLOW_LIM : FAST_LIM;

  always_ff @(posedge clk) begin
    if (rst)               divQ <= DIV_STD;
    else if (strb.loadDiv) divQ <= strb.divVal;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cntQ <= '0;
    else if (strb.restart)   cntQ <= '0;
    else if (cntQ == limNow) cntQ <= '0;
    else                     cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= {inSvc, serBusy};
  end

  assign curDiv  = divQ;
  assign cycleEn = (cntQ == limNow);

  // R2/R3: count stays inside the active period
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cntQ <= limNow);

  // R4: rate change restarts the count
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
    strb.restart |=> (cntQ == '0));

  // R2: enable is a single-clock pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cycleEn |=> !cycleEn);

  // R11: status follows inputs one clock later
  a_r11_status_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (statusQ == $past({inSvc, serBusy})));

endmodule

// File: rtl/clk_rate_switchback.sv
module clk_rate_switchback
  import crs_pkg::*;
#(
  parameter int NUM_SER  = 2,
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgDiv,
  input  logic               cfgSwbEn,
  input  logic               irqAck,
  input  logic [NUM_SER-1:0] rxStart,
  input  logic [NUM_SER-1:0] txLoad,
  input  logic [NUM_SER-1:0] serBusy,
  input  logic [2:0]         inSvc,
  output logic               cycleEn,
  output logic [1:0]         divCode,
  output logic               swbEn,
  output logic [NUM_SER+2:0] status
);

  rateStrobe_t strb;

  crs_control #(.NUM_SER(NUM_SER)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgDiv(cfgDiv),
    .cfgSwbEn(cfgSwbEn), .irqAck(irqAck), .rxStart(rxStart),
    .txLoad(txLoad), .serBusy(serBusy), .curDiv(divCode),
    .strb(strb), .swbEnQ(swbEn)
  );

  crs_datapath #(.NUM_SER(NUM_SER), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inSvc(inSvc), .serBusy(serBusy),
    .curDiv(divCode), .cycleEn(cycleEn), .statusQ(status)
  );

endmodule

// File: tb/tb_clk_rate_switchback.sv
module tb_clk_rate_switchback;

  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgDiv = 2'b00;
  logic cfgSwbEn = 1'b0;
  logic irqAck = 1'b0;
  logic [NS-1:0] rxStart = '0;
  logic [NS-1:0] txLoad = '0;
  logic [NS-1:0] serBusy = '0;
  logic [2:0] inSvc = '0;
  logic cycleEn;
  logic [1:0] divCode;
  logic swbEn;
  logic [NS+2:0] status;

  int checks = 0;
  int errors = 0;

  clk_rate_switchback #(.NUM_SER(NS)) dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgDiv(cfgDiv),
    .cfgSwbEn(cfgSwbEn), .irqAck(irqAck), .rxStart(rxStart),
    .txLoad(txLoad), .serBusy(serBusy), .inSvc(inSvc),
    .cycleEn(cycleEn), .divCode(divCode), .swbEn(swbEn), .status(status)
  );

  always #10 clk = ~clk;

  // reference model built from the requirements
  logic [1:0] mCode = 2'b00;
  logic mSwb = 1'b0;
  int mCnt = 0;
  logic [NS+2:0] mStat = '0;

  function automatic int limOf(input logic [1:0] c);
    return (c == 2'b11) ? 1024 : 4;
  endfunction

  always @(posedge clk) begin
    logic trig;
    logic [1:0] nc;
    if (rst) begin
      mCode <= 2'b00; mSwb <= 1'b0; mCnt <= 0; mStat <= '0;
    end else begin
      trig = mSwb && (mCode == 2'b11) && (irqAck || (|rxStart) || (|txLoad));
      nc = mCode;
      if (cfgWrEn && serBusy == '0) nc = cfgDiv;
      if (trig) nc = 2'b00;
      if (cfgWrEn) mSwb <= cfgSwbEn;
      mCode <= nc;
      if ((nc == 2'b11) != (mCode == 2'b11)) mCnt <= 0;
      else if (mCnt == limOf(mCode) - 1) mCnt <= 0;
      else mCnt <= mCnt + 1;
      mStat <= {inSvc, serBusy};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock; compare all outputs with the model at the falling edge
  task automatic cyc();
    logic expEn;
    @(negedge clk);
    expEn = (mCnt == limOf(mCode) - 1);
    check(cycleEn == expEn, "R2 cycleEn", int'(cycleEn), int'(expEn));
    check(divCode == mCode, "R4 divCode", int'(divCode), int'(mCode));
    check(swbEn == mSwb, "R10 swbEn", int'(swbEn), int'(mSwb));
    check(status == mStat, "R11 status", int'(status), int'(mStat));
  endtask

  task automatic writeCfg(input logic [1:0] d, input logic s);
    cfgWrEn = 1'b1; cfgDiv = d; cfgSwbEn = s;
    cyc();
    cfgWrEn = 1'b0;
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin cyc(); n++; end while (!cycleEn && n < 3000);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  initial begin
    int n;
    int unused;
    unused = $urandom(32'h5eed1234);
    rst = 1'b1;
    idle(3);
    // R1: reset state
    check(divCode == 2'b00, "R1 divCode", int'(divCode), 0);
    check(swbEn == 1'b0, "R1 swbEn", int'(swbEn), 0);
    check(status == '0, "R1 status", int'(status), 0);
    rst = 1'b0;
    waitTick(n);
    check(n == 3, "R1 first tick", n, 3);

    // R2: standard codes
    waitTick(n); check(n == 4, "R2 period 00", n, 4);
    writeCfg(2'b01, 1'b0); waitTick(n); waitTick(n); check(n == 4, "R2 period 01", n, 4);
    writeCfg(2'b10, 1'b0); waitTick(n); waitTick(n); check(n == 4, "R2 period 10", n, 4);

    // R4/R3: enter slow, first tick and period
    idle(1);
    writeCfg(2'b11, 1'b0); waitTick(n); check(n == 1023, "R4 first slow tick", n, 1023);
    waitTick(n); check(n == 1024, "R3 slow period", n, 1024);
    idle(100);
    writeCfg(2'b11, 1'b0); waitTick(n); check(n == 923, "R4 same-rate write keeps phase", n, 923);
    idle(200);
    writeCfg(2'b00, 1'b0); waitTick(n); check(n == 3, "R4 first fast tick", n, 3);

    // R5: interrupt acknowledge
    writeCfg(2'b11, 1'b1); idle(50);
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    check(divCode == 2'b00, "R5 code after ack", int'(divCode), 0);
    waitTick(n); check(n == 3, "R5 fast tick after ack", n, 3);

    // R6: start bit on port 1
    writeCfg(2'b11, 1'b1); idle(70);
    rxStart = 2'b10; cyc(); rxStart = '0;
    check(divCode == 2'b00, "R6 code after start bit", int'(divCode), 0);
    waitTick(n); check(n == 3, "R6 fast tick", n, 3);

    // R7: transmit load on port 0
    writeCfg(2'b11, 1'b1); idle(30);
    txLoad = 2'b01; cyc(); txLoad = '0;
    check(divCode == 2'b00, "R7 code after tx load", int'(divCode), 0);

    // R8: disabled switchback
    writeCfg(2'b11, 1'b0); idle(10);
    irqAck = 1'b1; rxStart = 2'b01; txLoad = 2'b10; cyc();
    irqAck = 1'b0; rxStart = '0; txLoad = '0; idle(2);
    check(divCode == 2'b11, "R8 stays slow", int'(divCode), 3);

    // R9: events in standard mode keep phase
    writeCfg(2'b00, 1'b1);
    waitTick(n); cyc();
    irqAck = 1'b1; rxStart = 2'b11; cyc(); irqAck = 1'b0; rxStart = '0;
    waitTick(n); check(n == 2, "R9 phase unchanged", n, 2);

    // R10: busy blocks divisor field only
    serBusy = 2'b01; idle(2);
    writeCfg(2'b11, 1'b0);
    check(divCode == 2'b00, "R10 divisor ignored", int'(divCode), 0);
    check(swbEn == 1'b0, "R10 enable written", int'(swbEn), 0);
    serBusy = 2'b00; idle(1);
    writeCfg(2'b11, 1'b1);
    serBusy = 2'b10;
    writeCfg(2'b00, 1'b1);
    check(divCode == 2'b11, "R10 exit write ignored", int'(divCode), 3);
    serBusy = 2'b00;

    // R11: status layout
    inSvc = 3'b101; serBusy = 2'b10; cyc();
    check(status == 5'b10110, "R11 status bits", int'(status), 22);
    inSvc = 3'b000; serBusy = 2'b00; cyc();

    // R12: switchback beats simultaneous slow write
    writeCfg(2'b11, 1'b1); idle(5);
    irqAck = 1'b1; writeCfg(2'b11, 1'b1); irqAck = 1'b0;
    check(divCode == 2'b00, "R12 switchback wins", int'(divCode), 0);

    // constrained random phase
    for (int i = 0; i < 40000; i++) begin
      cfgWrEn = ($urandom_range(299) == 0);
      cfgDiv = 2'($urandom_range(3));
      cfgSwbEn = ($urandom_range(3) != 0);
      irqAck = ($urandom_range(1499) == 0);
      rxStart = '0; txLoad = '0;
      if ($urandom_range(2999) == 0) rxStart[$urandom_range(NS-1)] = 1'b1;
      if ($urandom_range(2999) == 0) txLoad[$urandom_range(NS-1)] = 1'b1;
      if ($urandom_range(199) == 0) serBusy[$urandom_range(NS-1)] ^= 1'b1;
      if ($urandom_range(49) == 0) inSvc = 3'($urandom_range(7));
      cyc();
    end
    cfgWrEn = 1'b0; irqAck = 1'b0; rxStart = '0; txLoad = '0;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule